// File: doc/BRIEF.md
# Ethernet Receive Frame Qualifier

This block watches a byte-wide receive stream coming out of a media-independent interface and, for each frame, decides whether the frame may enter the packet queue or must be dropped. It tracks the frame length from the first destination-address byte through the last frame check sequence byte. It checks that length against a fixed lower bound of 64 and a programmable upper bound. It also checks that the frame ended on a whole octet and runs a CRC-32 check over the whole frame. When the optional broadcast filter is enabled, frames whose destination address is all ones are dropped.

One cycle after the last byte, the block presents a single-cycle verdict with a 3-bit reason code. Independently, it compares the downstream queue fill level with a programmable threshold. From that comparison it drives a status flag and a flow-control request. The request releases with hysteresis, only once the level falls below the threshold minus a programmable margin.

Top module: `eth_rx_qualifier`

## Requirements
- R1: A frame of fewer than 64 bytes is discarded with reason code 1 (runt).
- R2: The effective maximum length is the configured maximum, capped at 2016. A frame longer than the effective maximum is discarded with reason code 2 (oversize). A frame of exactly the effective maximum is accepted.
- R3: The length counter saturates at its all-ones value instead of wrapping, so a frame far longer than the counter range is still reported with reason code 2.
- R4: A frame whose end-of-frame beat carries the dribble indication (a bit count that is not a whole number of octets) is discarded with reason code 3.
- R5: The CRC-32 is computed as follows: polynomial 0x04C11DB7, register preset to all ones, bits processed LSB first, transmitted FCS equal to the inverted CRC, low byte first. A frame whose FCS fails this check is discarded with reason code 4. The check passes when the bit-reversed register equals the residue 0xC704DD7B.
- R6: With the broadcast filter enabled, a frame whose first six bytes are all 0xFF is discarded with reason code 5. With the filter disabled, the same frame is accepted.
- R7: When several checks fail, the reported code is the lowest failing code.
- R8: The verdict (verdict valid, accept, reason) is valid for exactly one cycle, the cycle after the clock edge that takes in the end-of-frame byte. Accept is high exactly when the reason is 0 (accepted). After reset, verdict valid, flow request and status are low.
- R9: Frame length counts every byte from the start-of-frame byte through the end-of-frame byte inclusive, the FCS included.
- R10: Status and flow request go high at the clock edge after the queue level reaches or exceeds the threshold. Status falls as soon as the level is below the threshold.
- R11: Once raised, the flow request stays high until the level falls below the threshold minus the margin (floor zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Byte valid on rx_data_i |
| rx_data_i | input | 8 | Received byte |
| rx_sof_i | input | 1 | First byte of a frame, qualified by rx_valid_i |
| rx_eof_i | input | 1 | Last byte of a frame, qualified by rx_valid_i |
| rx_dribble_i | input | 1 | Trailing non-octet bits, sampled on the end-of-frame beat |
| cfg_max_len_i | input | 11 | Programmable maximum frame length in bytes |
| cfg_bcast_drop_i | input | 1 | Enable broadcast discard |
| q_level_i | input | 8 | Downstream queue occupancy |
| cfg_q_thresh_i | input | 8 | Occupancy threshold |
| cfg_q_margin_i | input | 8 | Hysteresis margin below the threshold |
| verdict_valid_o | output | 1 | Verdict strobe, one cycle per frame |
| accept_o | output | 1 | Frame accepted |
| reason_o | output | 3 | Discard reason code |
| fc_req_o | output | 1 | Flow-control request |
| q_status_o | output | 1 | Occupancy at or above threshold |

## Verification
The assertions assume well-formed framing. Every frame opens with a start-of-frame beat and closes with exactly one end-of-frame beat, and the configuration stays stable while a frame is in flight. The bench keeps to this by driving whole frames from a single task that sets the start and end markers from the byte index. Configuration and queue level change only while no byte is valid. Frames are built with a correct FCS computed in the bench, then corrupted on purpose only where a vector asks for it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [2:0] {
    RSN_OK      = 3'd0,
    RSN_RUNT    = 3'd1,
    RSN_OVERSZ  = 3'd2,
    RSN_MISALGN = 3'd3,
    RSN_BADFCS  = 3'd4,
    RSN_BCAST   = 3'd5
  } reason_e;

  localparam int unsigned MIN_FRAME = 64;
  localparam int unsigned MAX_CAP   = 2016;
  localparam int unsigned DA_BYTES  = 6;
  // reflected-register form of the 802.3 residue 0xC704DD7B
  localparam logic [31:0] CRC_RESIDUE_REFL = 32'hDEBB20E3;
  localparam logic [31:0] CRC_POLY_REFL    = 32'hEDB88320;
endpackage

// File: rtl/rxq_crc.sv
module rxq_crc
  import rxq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       beat_i,
  input  logic       sof_i,
  input  logic [7:0] data_i,
  output logic       good_o
);
  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = sof_i ? 32'hFFFF_FFFF : crc_q;
    crc_d = crc_d ^ {24'd0, data_i};
    for (int b = 0; b < 8; b++) begin
      crc_d = crc_d[0] ? ((crc_d >> 1) ^ CRC_POLY_REFL) : (crc_d >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= 32'hFFFF_FFFF;
    else if (beat_i) crc_q <= crc_d;
  end

  assign good_o = (crc_d == CRC_RESIDUE_REFL);
endmodule

// File: rtl/rxq_frame_track.sv
module rxq_frame_track
  import rxq_pkg::*;
#(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             sof_i,
  input  logic [7:0]       data_i,
  input  logic [LEN_W-1:0] max_len_i,
  output logic [LEN_W-1:0] len_o,
  output logic             oversz_o,
  output logic             bcast_o
);
  localparam logic [LEN_W-1:0] LEN_SAT = '1;
  localparam logic [LEN_W-1:0] DA_LEN  = LEN_W'(DA_BYTES);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             ovs_q, ovs_d;
  logic             bc_q, bc_d, bc_base;

  always_comb begin
    if (sof_i)               cnt_d = LEN_W'(1);
    else if (cnt_q == LEN_SAT) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + LEN_W'(1);

    ovs_d   = ((sof_i ? 1'b0 : ovs_q) | (cnt_d > max_len_i));
    bc_base = sof_i ? 1'b1 : bc_q;
    bc_d    = (cnt_d <= DA_LEN) ? (bc_base & (data_i == 8'hFF)) : bc_base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovs_q <= 1'b0;
      bc_q  <= 1'b0;
    end else if (beat_i) begin
      cnt_q <= cnt_d;
      ovs_q <= ovs_d;
      bc_q  <= bc_d;
    end
  end

  assign len_o    = cnt_d;
  assign oversz_o = ovs_d;
  assign bcast_o  = bc_d & (cnt_d >= DA_LEN);

  AST_LEN_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && !sof_i && cnt_q == LEN_SAT) |=> (cnt_q == LEN_SAT)); // R3
  AST_OVERSIZE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && !sof_i && ovs_q) |=> ovs_q); // R2
endmodule

// File: rtl/rxq_flow.sv
module rxq_flow #(
  parameter int unsigned QW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [QW-1:0] level_i,
  input  logic [QW-1:0] thresh_i,
  input  logic [QW-1:0] margin_i,
  output logic          fc_req_o,
  output logic          status_o
);
  logic [QW-1:0] low_mark;
  logic          fc_q, st_q, at_hi, below_lo;

  assign low_mark = (thresh_i > margin_i) ? (thresh_i - margin_i) : '0;
  assign at_hi    = (level_i >= thresh_i);
  assign below_lo = (level_i < low_mark);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fc_q <= 1'b0;
      st_q <= 1'b0;
    end else begin
      st_q <= at_hi;
      if (at_hi)         fc_q <= 1'b1;
      else if (below_lo) fc_q <= 1'b0;
    end
  end

  assign fc_req_o = fc_q;
  assign status_o = st_q;

  AST_FC_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i >= thresh_i) |=> fc_req_o); // R10
  AST_FC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_req_o && level_i >= low_mark) |=> fc_req_o); // R11
endmodule

// File: rtl/eth_rx_qualifier.sv
module eth_rx_qualifier
  import rxq_pkg::*;
#(
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned MAXCF_W = 11,
  parameter int unsigned QW      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_data_i,
  input  logic               rx_sof_i,
  input  logic               rx_eof_i,
  input  logic               rx_dribble_i,
  input  logic [MAXCF_W-1:0] cfg_max_len_i,
  input  logic               cfg_bcast_drop_i,
  input  logic [QW-1:0]      q_level_i,
  input  logic [QW-1:0]      cfg_q_thresh_i,
  input  logic [QW-1:0]      cfg_q_margin_i,
  output logic               verdict_valid_o,
  output logic               accept_o,
  output logic [2:0]         reason_o,
  output logic               fc_req_o,
  output logic               q_status_o
);
  localparam logic [LEN_W-1:0] CAP_LEN = LEN_W'(MAX_CAP);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME);

  logic             beat, sof_beat, eof_beat;
  logic [LEN_W-1:0] cfg_max_ext, eff_max, len_now;
  logic             ovs_now, bc_now, crc_good;
  reason_e          rsn_d;
  reason_e          rsn_q;
  logic             vld_q;

  assign beat     = rx_valid_i;
  assign sof_beat = rx_valid_i & rx_sof_i;
  assign eof_beat = rx_valid_i & rx_eof_i;

  assign cfg_max_ext = LEN_W'(cfg_max_len_i);
  assign eff_max     = (cfg_max_ext > CAP_LEN) ? CAP_LEN : cfg_max_ext;

  rxq_frame_track #(.LEN_W(LEN_W)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .beat_i    (beat),
    .sof_i     (sof_beat),
    .data_i    (rx_data_i),
    .max_len_i (eff_max),
    .len_o     (len_now),
    .oversz_o  (ovs_now),
    .bcast_o   (bc_now)
  );

  rxq_crc u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .beat_i (beat),
    .sof_i  (sof_beat),
    .data_i (rx_data_i),
    .good_o (crc_good)
  );

  rxq_flow #(.QW(QW)) u_flow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (q_level_i),
    .thresh_i (cfg_q_thresh_i),
    .margin_i (cfg_q_margin_i),
    .fc_req_o (fc_req_o),
    .status_o (q_status_o)
  );

  // lowest failing code wins
  always_comb begin
    if (len_now < MIN_LEN)                rsn_d = RSN_RUNT;
    else if (ovs_now)                     rsn_d = RSN_OVERSZ;
    else if (rx_dribble_i)                rsn_d = RSN_MISALGN;
    else if (!crc_good)                   rsn_d = RSN_BADFCS;
    else if (cfg_bcast_drop_i && bc_now)  rsn_d = RSN_BCAST;
    else                                  rsn_d = RSN_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      rsn_q <= RSN_OK;
    end else begin
      vld_q <= eof_beat;
      if (eof_beat) rsn_q <= rsn_d;
    end
  end

  assign verdict_valid_o = vld_q;
  assign reason_o        = rsn_q;
  assign accept_o        = vld_q & (rsn_q == RSN_OK);

  AST_ACCEPT_MATCHES_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |-> (accept_o == (reason_o == 3'd0))); // R8
  AST_REASON_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |-> (reason_o <= 3'd5)); // R7
  AST_NO_ACCEPT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !verdict_valid_o |-> !accept_o); // R8
endmodule

// File: tb/sim_eth_rx_qualifier.sv
module sim_eth_rx_qualifier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_drib = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [10:0] cfg_max = 11'd1518;
  logic        cfg_bdrop = 1'b0;
  logic [7:0]  q_level = '0, q_thresh = 8'd10, q_margin = 8'd3;
  logic        vld, acc, fc, st;
  logic [2:0]  rsn;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] frm [0:4199];

  always #5 clk = ~clk;

  eth_rx_qualifier u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .rx_dribble_i(rx_drib),
    .cfg_max_len_i(cfg_max), .cfg_bcast_drop_i(cfg_bdrop), .q_level_i(q_level),
    .cfg_q_thresh_i(q_thresh), .cfg_q_margin_i(q_margin),
    .verdict_valid_o(vld), .accept_o(acc), .reason_o(rsn),
    .fc_req_o(fc), .q_status_o(st)
  );

  typedef struct packed {
    logic [12:0] len;
    logic        bad;
    logic        drib;
    logic        bc;
    logic [10:0] mx;
    logic        bdrop;
    logic [2:0]  exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{13'd64,   1'b0, 1'b0, 1'b0, 11'd1518, 1'b0, 3'd0}, // R1 R9 minimum
    '{13'd63,   1'b0, 1'b0, 1'b0, 11'd1518, 1'b0, 3'd1}, // R1
    '{13'd1518, 1'b0, 1'b0, 1'b0, 11'd1518, 1'b0, 3'd0}, // R2 exact max
    '{13'd1519, 1'b0, 1'b0, 1'b0, 11'd1518, 1'b0, 3'd2}, // R2
    '{13'd2016, 1'b0, 1'b0, 1'b0, 11'd2047, 1'b0, 3'd0}, // R2 cap
    '{13'd2017, 1'b0, 1'b0, 1'b0, 11'd2047, 1'b0, 3'd2}, // R2 cap
    '{13'd100,  1'b0, 1'b1, 1'b0, 11'd1518, 1'b0, 3'd3}, // R4
    '{13'd100,  1'b1, 1'b0, 1'b0, 11'd1518, 1'b0, 3'd4}, // R5
    '{13'd100,  1'b0, 1'b0, 1'b1, 11'd1518, 1'b1, 3'd5}, // R6 drop on
    '{13'd100,  1'b0, 1'b0, 1'b1, 11'd1518, 1'b0, 3'd0}, // R6 drop off
    '{13'd40,   1'b1, 1'b1, 1'b1, 11'd1518, 1'b1, 3'd1}, // R7
    '{13'd2000, 1'b1, 1'b1, 1'b0, 11'd1518, 1'b0, 3'd2}, // R7
    '{13'd100,  1'b1, 1'b1, 1'b0, 11'd1518, 1'b0, 3'd3}, // R7
    '{13'd100,  1'b1, 1'b0, 1'b1, 11'd1518, 1'b1, 3'd4}, // R7
    '{13'd4100, 1'b0, 1'b0, 1'b0, 11'd2016, 1'b0, 3'd2}  // R3 beyond counter range
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic build(input int len, input logic bad, input logic bc);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < len - 4; i++) begin
      if (i < 6) frm[i] = bc ? 8'hFF : 8'h02 + 8'(i);
      else       frm[i] = 8'(i * 7 + 3);
      c = c ^ {24'd0, frm[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    for (int j = 0; j < 4; j++) frm[len - 4 + j] = c[8*j +: 8];
    if (bad) frm[len - 4] = frm[len - 4] ^ 8'h01;
  endtask

  task automatic send(input int len, input logic drib);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = frm[i];
      rx_sof   = (i == 0);
      rx_eof   = (i == len - 1);
      rx_drib  = (i == len - 1) && drib;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_drib = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset verdict_valid", 32'(vld), 32'd0);
    check("R8 reset fc_req", 32'(fc), 32'd0);
    check("R8 reset status", 32'(st), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      cfg_max   = VECS[v].mx;
      cfg_bdrop = VECS[v].bdrop;
      build(int'(VECS[v].len), VECS[v].bad, VECS[v].bc);
      send(int'(VECS[v].len), VECS[v].drib);
      check($sformatf("R1-R7 vec%0d reason", v), 32'(rsn), 32'(VECS[v].exp));
      check($sformatf("R8 vec%0d valid", v), 32'(vld), 32'd1);
      check($sformatf("R8 vec%0d accept", v), 32'(acc), 32'(VECS[v].exp == 3'd0));
      @(negedge clk);
      check($sformatf("R8 vec%0d single cycle", v), 32'(vld), 32'd0);
    end

    // R9: 60 bytes before FCS plus 4 FCS bytes = 64 accepted
    cfg_max = 11'd64; cfg_bdrop = 1'b0;
    build(64, 1'b0, 1'b0);
    send(64, 1'b0);
    check("R9 fcs counted in length", 32'(rsn), 32'd0);
    @(negedge clk);

    // back-to-back frames: second frame's verdict must be independent
    cfg_max = 11'd1518;
    build(70, 1'b1, 1'b0);
    send(70, 1'b0);
    check("R5 bad fcs", 32'(rsn), 32'd4);
    build(70, 1'b0, 1'b0);
    send(70, 1'b0);
    check("R5 good fcs after bad", 32'(rsn), 32'd0);
    @(negedge clk);

    // flow control, thresh 10 margin 3 -> release below 7
    q_level = 8'd9;  @(negedge clk);
    check("R10 below thresh fc", 32'(fc), 32'd0);
    check("R10 below thresh status", 32'(st), 32'd0);
    q_level = 8'd10; @(negedge clk);
    check("R10 at thresh fc", 32'(fc), 32'd1);
    check("R10 at thresh status", 32'(st), 32'd1);
    q_level = 8'd8;  @(negedge clk);
    check("R11 hold in band", 32'(fc), 32'd1);
    check("R10 status drops", 32'(st), 32'd0);
    q_level = 8'd7;  @(negedge clk);
    check("R11 hold at low mark", 32'(fc), 32'd1);
    q_level = 8'd6;  @(negedge clk);
    check("R11 release below low mark", 32'(fc), 32'd0);
    q_level = 8'd9;  @(negedge clk);
    check("R11 no re-raise below thresh", 32'(fc), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule